// File: doc/BRIEF.md
# Buck PWM Gate-Drive Sequencer

This block turns the digital decisions of a fixed-frequency, voltage-mode synchronous step-down controller into the two switch enables: `gh_on` for the high-side switch and `gl_on` for the low-side (synchronous rectifier) switch. It runs on a fast clock. A period-start strobe opens each switching period and a half-period strobe marks the middle of it. The high-side demand rises at every period start and falls on the trailing edge, when the comparator flag reports that the ramp has crossed the error voltage. The analog ramp, the amplifier, the comparator and the drivers are outside the block. They reach it as single-bit flags.

Four rules sit on top of plain trailing-edge modulation. First, a minimum high-side on-time is enforced. Second, the two enables are separated by a dead time counted in clock ticks. Third, the low side is kept off at start-up until the high side has actually conducted, or until the soft-start flag reports the threshold has been passed. Fourth, the high side cannot stay on indefinitely: after a run of full-duty periods, demand is cut at the half-period strobe of the following period, so the low side conducts for the rest of that period and the bootstrap supply is recharged. An idle/fault input forces both switches off. It clears the start-up permit and the full-duty run.

Top module: `buck_gate_sequencer`

## Requirements
- R1: After synchronous reset, `gh_on` and `gl_on` are both 0 and stay 0 until a period start or the soft-start flag arrives.
- R2: The high-side demand is set at the clock edge that samples `period_start`. It is cleared at the edge that samples `cmp_trip` high, subject to R3. Once cleared, it stays clear until the next `period_start`. Each enable follows the demand one edge later, plus any dead time from R4.
- R3: Once `gh_on` rises, a comparator trip cannot make it fall before it has been high for MIN_ON_TICKS sampled cycles.
- R4: `gh_on` and `gl_on` are never high together. When one falls and the other is next to rise, both stay low for exactly DEAD_TICKS cycles in between (idle excepted).
- R5: After reset, the low side may not turn on until `gh_on` has been high at least once since the last reset or idle, unless R6 applies.
- R6: `ss_ready` high grants the low-side permit without any high-side pulse, so `gl_on` can rise with no prior `gh_on`.
- R7: After FULL_DUTY_LIMIT consecutive periods in which demand stayed high from start to end, demand is cut at the `half_period` strobe of the next period. `gl_on` then follows after the dead time and stays on for the rest of that period. In earlier periods of the run, no cut occurs.
- R8: The full-duty run restarts from zero after any period in which demand drops, whether by trip or by idle.
- R9: While `idle` is high, both enables are 0 from the first edge that samples it, and `period_start` is ignored.
- R10: Entering idle withdraws the low-side permit. After idle is released with `ss_ready` low, `gl_on` stays 0 until the high side has conducted again.
- R11: While demand is clear and the permit is held, `gl_on` is on from the end of the dead time until the next period's demand takes over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sequencing clock |
| rst | input | 1 | Synchronous active-high reset |
| period_start | input | 1 | One-cycle strobe opening a switching period |
| half_period | input | 1 | One-cycle strobe at mid-period |
| cmp_trip | input | 1 | Comparator flag: ramp has crossed the error level |
| ss_ready | input | 1 | Soft-start level above its low-side release threshold |
| idle | input | 1 | Fault/idle request; both switches off |
| gh_on | output | 1 | High-side switch enable |
| gl_on | output | 1 | Low-side switch enable |

## Verification
The hardest state to reach is the forced half-period cut. It appears only after twenty uninterrupted full-demand periods, and only if nothing has reset the run in between. The stimulus holds the comparator flag low across more than twenty whole periods. It repeats the run after a single tripped period, and again after an idle period, and checks that the cut lands exactly in the twenty-first period and nowhere earlier. Steady-state pulse widths are checked against a vector table of trip positions. The table includes a trip that arrives before the minimum on-time has elapsed.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

    // Which switch the output stage is driving.
    typedef enum logic [1:0] {
        DRV_OFF  = 2'd0,
        DRV_HIGH = 2'd1,
        DRV_LOW  = 2'd2
    } drv_e;

    // Control inputs gathered at the top edge.
    typedef struct packed {
        logic period_start;
        logic half_period;
        logic cmp_trip;
        logic ss_ready;
        logic idle;
    } ctl_in_t;

    // Desired switch, before dead-time insertion.
    function automatic drv_e pick_target(input logic idle,
                                         input logic hs_req,
                                         input logic ls_ok);
        if (idle)   return DRV_OFF;
        if (hs_req) return DRV_HIGH;
        if (ls_ok)  return DRV_LOW;
        return DRV_OFF;
    endfunction

endpackage

// File: rtl/buck_hs_latch.sv
module buck_hs_latch #(
    parameter int MIN_ON_TICKS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic idle,
    input  logic period_start,
    input  logic half_period,
    input  logic cmp_trip,
    input  logic force_cut,
    input  logic gh_on,
    output logic hs_req
);
    // MIN_ON_TICKS must be 2 or more; the compare accounts for the
    // one-edge lag between demand and the gate output.
    localparam int MIN_LIM = (MIN_ON_TICKS >= 2) ? MIN_ON_TICKS - 2 : 0;
    localparam int OCW     = $clog2(MIN_LIM + 2);

    logic [OCW-1:0] on_cnt;
    logic           min_met;
    logic           trip_cut;
    logic           full_cut;

    assign min_met  = gh_on && (on_cnt >= OCW'(MIN_LIM));
    assign trip_cut = cmp_trip && min_met;
    assign full_cut = half_period && force_cut;

    always_ff @(posedge clk) begin
        if (rst || idle) begin
            hs_req <= 1'b0;
            on_cnt <= '0;
        end else if (period_start) begin
            hs_req <= 1'b1;
            on_cnt <= '0;
        end else begin
            if (hs_req && gh_on && (on_cnt < OCW'(MIN_LIM)))
                on_cnt <= on_cnt + 1'b1;
            if (hs_req && (trip_cut || full_cut))
                hs_req <= 1'b0;
        end
    end

    // R2: a period start outside idle always raises demand
    assert_demand_set_R2: assert property (@(posedge clk) disable iff (rst)
        (period_start && !idle) |=> hs_req);

    // R2: cleared demand waits for the next period start
    assert_demand_stays_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (!hs_req && !period_start) |=> !hs_req);

endmodule

// File: rtl/buck_full_duty_track.sv
module buck_full_duty_track #(
    parameter int FULL_DUTY_LIMIT = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic idle,
    input  logic period_start,
    input  logic hs_req,
    output logic force_cut
);
    localparam int CW = $clog2(FULL_DUTY_LIMIT + 1);

    logic [CW-1:0] run_cnt;
    logic          held;   // demand unbroken since the last period start

    always_ff @(posedge clk) begin
        if (rst || idle) begin
            run_cnt <= '0;
            held    <= 1'b0;
        end else if (period_start) begin
            held <= 1'b1;
            if (held && hs_req) begin
                if (run_cnt < CW'(FULL_DUTY_LIMIT))
                    run_cnt <= run_cnt + 1'b1;
            end else begin
                run_cnt <= '0;
            end
        end else if (!hs_req) begin
            held <= 1'b0;
        end
    end

    assign force_cut = (run_cnt == CW'(FULL_DUTY_LIMIT));

    // R7: the run never counts past its limit
    assert_run_bounded_R7: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= CW'(FULL_DUTY_LIMIT));

    // R8: a broken period restarts the run
    assert_run_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (period_start && !held && !idle) |=> (run_cnt == '0));

    // R8: idle restarts the run
    assert_idle_restart_R8: assert property (@(posedge clk) disable iff (rst)
        idle |=> (run_cnt == '0));

endmodule

// File: rtl/buck_ls_permit.sv
module buck_ls_permit (
    input  logic clk,
    input  logic rst,
    input  logic idle,
    input  logic ss_ready,
    input  logic gh_on,
    output logic permit
);
    always_ff @(posedge clk) begin
        if (rst || idle)
            permit <= 1'b0;
        else if (gh_on || ss_ready)
            permit <= 1'b1;
    end

    // R5: once granted, the permit holds until idle or reset
    assert_permit_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (permit && !idle) |=> permit);

    // R10: idle withdraws the permit
    assert_idle_drops_permit_R10: assert property (@(posedge clk) disable iff (rst)
        idle |=> !permit);

endmodule

// File: rtl/buck_deadtime_gate.sv
module buck_deadtime_gate
    import buck_seq_pkg::*;
#(
    parameter int DEAD_TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic idle,
    input  logic hs_req,
    input  logic permit,
    output logic gh_on,
    output logic gl_on
);
    // DEAD_TICKS must be 1 or more.
    localparam int DCW = $clog2(DEAD_TICKS + 1);

    drv_e           cur;
    drv_e           target;
    logic [DCW-1:0] dead_cnt;

    assign target = pick_target(idle, hs_req, permit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= DRV_OFF;
            dead_cnt <= '0;
        end else if (cur != DRV_OFF) begin
            if (target != cur) begin
                cur      <= DRV_OFF;
                dead_cnt <= DCW'(DEAD_TICKS - 1);
            end
        end else if (dead_cnt != '0) begin
            dead_cnt <= dead_cnt - 1'b1;
        end else if (target != DRV_OFF) begin
            cur <= target;
        end
    end

    assign gh_on = (cur == DRV_HIGH);
    assign gl_on = (cur == DRV_LOW);

    // Observation registers for the dead-time properties.
    drv_e           last_on;
    logic [DCW-1:0] off_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_on <= DRV_OFF;
            off_run <= '0;
        end else begin
            if (cur != DRV_OFF) begin
                last_on <= cur;
                off_run <= '0;
            end else if (off_run < DCW'(DEAD_TICKS)) begin
                off_run <= off_run + 1'b1;
            end
        end
    end

    // R4: low side rises only after a full dead time following the high side
    assert_gap_before_low_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(gl_on) && (last_on == DRV_HIGH)) |-> (off_run >= DCW'(DEAD_TICKS)));

    // R4: high side rises only after a full dead time following the low side
    assert_gap_before_high_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(gh_on) && (last_on == DRV_LOW)) |-> (off_run >= DCW'(DEAD_TICKS)));

endmodule

// File: rtl/buck_gate_sequencer.sv
module buck_gate_sequencer
    import buck_seq_pkg::*;
#(
    parameter int DEAD_TICKS      = 2,
    parameter int MIN_ON_TICKS    = 3,
    parameter int FULL_DUTY_LIMIT = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic period_start,
    input  logic half_period,
    input  logic cmp_trip,
    input  logic ss_ready,
    input  logic idle,
    output logic gh_on,
    output logic gl_on
);
    ctl_in_t ctl;
    logic    hs_req;
    logic    force_cut;
    logic    permit;

    assign ctl = '{period_start: period_start,
                   half_period:  half_period,
                   cmp_trip:     cmp_trip,
                   ss_ready:     ss_ready,
                   idle:         idle};

    buck_hs_latch #(
        .MIN_ON_TICKS(MIN_ON_TICKS)
    ) u_latch (
        .clk          (clk),
        .rst          (rst),
        .idle         (ctl.idle),
        .period_start (ctl.period_start),
        .half_period  (ctl.half_period),
        .cmp_trip     (ctl.cmp_trip),
        .force_cut    (force_cut),
        .gh_on        (gh_on),
        .hs_req       (hs_req)
    );

    buck_full_duty_track #(
        .FULL_DUTY_LIMIT(FULL_DUTY_LIMIT)
    ) u_track (
        .clk          (clk),
        .rst          (rst),
        .idle         (ctl.idle),
        .period_start (ctl.period_start),
        .hs_req       (hs_req),
        .force_cut    (force_cut)
    );

    buck_ls_permit u_permit (
        .clk      (clk),
        .rst      (rst),
        .idle     (ctl.idle),
        .ss_ready (ctl.ss_ready),
        .gh_on    (gh_on),
        .permit   (permit)
    );

    buck_deadtime_gate #(
        .DEAD_TICKS(DEAD_TICKS)
    ) u_gate (
        .clk    (clk),
        .rst    (rst),
        .idle   (ctl.idle),
        .hs_req (hs_req),
        .permit (permit),
        .gh_on  (gh_on),
        .gl_on  (gl_on)
    );

    // High-side run length, kept for the minimum on-time property.
    localparam int GRW = $clog2(MIN_ON_TICKS + 1);
    logic [GRW-1:0] gh_run;

    always_ff @(posedge clk) begin
        if (rst)
            gh_run <= '0;
        else if (!gh_on)
            gh_run <= '0;
        else if (gh_run < GRW'(MIN_ON_TICKS))
            gh_run <= gh_run + 1'b1;
    end

    // R3: outside idle, a high-side pulse is never shorter than the minimum
    assert_min_on_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(gh_on) && !$past(idle)) |-> (gh_run >= GRW'(MIN_ON_TICKS)));

    // R9: idle turns both switches off at the next edge
    assert_idle_off_R9: assert property (@(posedge clk) disable iff (rst)
        idle |=> (!gh_on && !gl_on));

    // R5: the low side never rises without the permit
    assert_low_needs_permit_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(gl_on) |-> permit);

    // R7: demand drops without a trip or idle only at an armed half-period strobe
    assert_cut_cause_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(hs_req) && !$past(idle) && !$past(cmp_trip))
            |-> ($past(half_period) && $past(force_cut)));

endmodule

// File: tb/sim_buck_gate_sequencer.sv
module sim_buck_gate_sequencer;
    localparam int DEAD    = 2;
    localparam int MIN_ON  = 3;
    localparam int LIMIT   = 20;
    localparam int PER     = 20;
    localparam int HALF    = 10;
    localparam int NO_TRIP = 99;

    // Steady-state vectors: {trip cycle in period, expected GH cycles, expected GL cycles}
    localparam int N_VEC = 7;
    localparam int VEC [N_VEC][3] = '{
        '{ 1,  3, 13},
        '{ 5,  3, 13},
        '{ 6,  4, 12},
        '{ 9,  7,  9},
        '{13, 11,  5},
        '{16, 14,  2},
        '{17, 15,  1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic period_start = 1'b0;
    logic half_period  = 1'b0;
    logic cmp_trip     = 1'b0;
    logic ss_ready     = 1'b0;
    logic idle         = 1'b0;
    logic gh_on;
    logic gl_on;

    int total = 0;
    int fails = 0;
    int per_gh = 0;
    int per_gl = 0;
    int overlap_bad = 0;
    int gap_bad = 0;
    int gaps_seen = 0;
    int off_run = 0;
    int last_on = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    buck_gate_sequencer #(
        .DEAD_TICKS      (DEAD),
        .MIN_ON_TICKS    (MIN_ON),
        .FULL_DUTY_LIMIT (LIMIT)
    ) u0 (
        .clk          (clk),
        .rst          (rst),
        .period_start (period_start),
        .half_period  (half_period),
        .cmp_trip     (cmp_trip),
        .ss_ready     (ss_ready),
        .idle         (idle),
        .gh_on        (gh_on),
        .gl_on        (gl_on)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs, pass an edge, sample just after it.
    task automatic tick(input logic ps, input logic hp, input logic tr);
        period_start = ps;
        half_period  = hp;
        cmp_trip     = tr;
        @(posedge clk);
        #1;
        if (gh_on) per_gh++;
        if (gl_on) per_gl++;
        if (gh_on && gl_on) overlap_bad++;
        if (!gh_on && !gl_on) begin
            off_run++;
        end else begin
            if ((gh_on && last_on == 2) || (gl_on && last_on == 1)) begin
                gaps_seen++;
                if (off_run < DEAD) gap_bad++;
            end
            last_on = gh_on ? 1 : 2;
            off_run = 0;
        end
    endtask

    task automatic run_period(input int trip_at);
        per_gh = 0;
        per_gl = 0;
        for (int c = 0; c < PER; c++)
            tick(c == 0, c == HALF, c >= trip_at);
    endtask

    // Runs n full-demand periods; returns GL cycles over periods 2..n-1 and in period n.
    task automatic full_run(input int n, output int mid_gl, output int last_gl);
        mid_gl  = 0;
        last_gl = 0;
        for (int p = 1; p <= n; p++) begin
            run_period(NO_TRIP);
            if (p >= 2 && p < n) mid_gl += per_gl;
            if (p == n) last_gl = per_gl;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual %0d expected %0d", 200000, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int mid_gl;
        int last_gl;
        int sum_gl;
        int gh20;
        int gh21;
        int gl21;
        int gh22;

        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1: reset state
        per_gh = 0;
        per_gl = 0;
        tick(1'b0, 1'b0, 1'b0);
        check(gh_on == 1'b0, "R1 gh after reset", int'(gh_on), 0);
        check(gl_on == 1'b0, "R1 gl after reset", int'(gl_on), 0);

        // R5: no permit yet, low side stays off
        per_gl = 0;
        repeat (8) tick(1'b0, 1'b0, 1'b0);
        check(per_gl == 0, "R5 gl blocked before any high-side pulse", per_gl, 0);

        // R6: soft-start flag alone releases the low side
        ss_ready = 1'b1;
        repeat (3) tick(1'b0, 1'b0, 1'b0);
        check(gl_on == 1'b1, "R6 gl after ss_ready", int'(gl_on), 1);
        ss_ready = 1'b0;

        // R2 / R3 / R11: steady-state pulse widths from the vector table
        for (int i = 0; i < N_VEC; i++) begin
            repeat (3) run_period(VEC[i][0]);
            check(per_gh == VEC[i][1], (VEC[i][0] < 5) ? "R3 gh width min-on" : "R2 gh width",
                  per_gh, VEC[i][1]);
            check(per_gl == VEC[i][2], "R11 gl width", per_gl, VEC[i][2]);
        end

        // R7: full-duty timeout
        sum_gl = 0;
        gh20 = 0;
        gh21 = 0;
        gl21 = 0;
        gh22 = 0;
        for (int p = 1; p <= 22; p++) begin
            run_period(NO_TRIP);
            if (p >= 2 && p <= 20) sum_gl += per_gl;
            if (p == 20) gh20 = per_gh;
            if (p == 21) begin gh21 = per_gh; gl21 = per_gl; end
            if (p == 22) gh22 = per_gh;
        end
        check(sum_gl == 0, "R7 no low-side pulse inside the run", sum_gl, 0);
        check(gh20 == PER, "R7 period 20 full high side", gh20, PER);
        check(gh21 == HALF + 1, "R7 period 21 high side cut at half", gh21, HALF + 1);
        check(gl21 == PER - HALF - 1 - DEAD, "R7 period 21 refresh pulse", gl21, PER - HALF - 1 - DEAD);
        check(gh22 == PER - 1 - DEAD, "R7 period 22 resumes", gh22, PER - 1 - DEAD);

        // R8: a tripped period restarts the run
        run_period(9);
        repeat (12) run_period(NO_TRIP);
        run_period(9);
        full_run(21, mid_gl, last_gl);
        check(mid_gl == 0, "R8 no early cut after tripped period", mid_gl, 0);
        check(last_gl == PER - HALF - 1 - DEAD, "R8 cut in 21st period", last_gl, PER - HALF - 1 - DEAD);

        // R9: idle period, both off and strobes ignored
        repeat (12) run_period(NO_TRIP);
        idle = 1'b1;
        run_period(NO_TRIP);
        idle = 1'b0;
        check(per_gh == 0, "R9 gh during idle", per_gh, 0);
        check(per_gl == 0, "R9 gl during idle", per_gl, 0);

        // R10: permit withdrawn by idle
        per_gl = 0;
        repeat (6) tick(1'b0, 1'b0, 1'b0);
        check(per_gl == 0, "R10 gl blocked after idle", per_gl, 0);

        // R8 via idle, and R5 permit regained after a high-side pulse
        full_run(21, mid_gl, last_gl);
        check(mid_gl == 0, "R8 no early cut after idle", mid_gl, 0);
        check(last_gl == PER - HALF - 1 - DEAD, "R8 cut in 21st period after idle", last_gl, PER - HALF - 1 - DEAD);
        check(last_gl > 0, "R5 low side allowed once high side has conducted", last_gl, 1);

        // R4: non-overlap and dead time over the whole run
        check(overlap_bad == 0, "R4 overlap", overlap_bad, 0);
        check(gap_bad == 0, "R4 short dead time", gap_bad, 0);
        check(gaps_seen > 0, "R4 transitions observed", gaps_seen, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule